// File: doc/BRIEF.md
# Ping-Pong One-Shot DMA Channel

This block is one DMA channel that owns two descriptor sets and alternates between them. Each set holds a buffer address, a byte length and a command word. While one set (the live set) drives the transfer, software loads the other. When the live set's length runs out, the channel marks that set finished, raises its interrupt and, if the other set is armed, continues on it in the next cycle with no software step in between. Back-to-back buffers therefore stream without a gap.

Software reaches the channel through a small 32-bit word-indexed register port. The channel window is 0x20 bytes, so a second channel placed at the next 0x20 stride never overlaps it. A register's byte offset is `reg_idx * 4`. Set 0 lives at byte offsets 0x00/0x04/0x08 and set 1 at 0x10/0x14/0x18, holding address, length and command in that order. Memory traffic uses a request/acknowledge handshake that moves one 32-bit word per acknowledge. A peripheral side supplies words (ready/take) or accepts them (need/put). The direction bit of the live set selects which side is used.

Top module: `pp_dma_chan`

## Requirements
- R1: After a synchronous active-low reset, both address and length registers read 0, set 1's command reads 0, set 0's command reads 0x4 (set 0 live, bit 2), `irq` is low and `mem_req` is low.
- R2: Register index bit 2 selects the set and bits 1:0 select address (0), length (1) or command (2). Address and length are stored with their two low bits cleared. In the command word, bit 0 is arm, bit 1 is done, bit 2 is live (read-only) and bit 4 is direction.
- R3: With direction 0, each word offered on `src_data` while `src_rdy` is high is taken with a one-cycle `src_take` and written to memory at the live address. On each `mem_ack`, the address rises by 4 and the length falls by 4.
- R4: With direction 1, each word is read from memory when `snk_need` is high. It is presented on `snk_data` with a one-cycle `snk_put` in the cycle after its `mem_ack`.
- R5: When the live set's length reaches zero, that set's arm bit clears, its done bit sets and `irq` goes high.
- R6: Writing 1 to a done bit clears it, and `irq` falls once no done bit is set. Writing 0 to a done bit leaves it set.
- R7: If the other set is armed when the live set completes, the live bit moves to it and its transfer starts without any register access.
- R8: If the other set is not armed at completion, the live bit stays on the finished set and no memory request is made.
- R9: While the live set is unarmed and the other set becomes armed, the live bit moves to the other set and it runs.
- R10: While the live set is armed, writes to its address, length, arm and direction are ignored. Writes to the other set take effect.
- R11: An armed live set whose length is zero completes with no memory request, and its address is left unchanged.
- R12: `mem_req`, once raised, stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index in the channel window (bit 2 = set) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted / data valid |
| src_rdy | input | 1 | Peripheral has a word ready |
| src_data | input | 32 | Word from the peripheral |
| src_take | output | 1 | Word on `src_data` consumed this cycle |
| snk_need | input | 1 | Peripheral requests a word |
| snk_data | output | 32 | Word to the peripheral |
| snk_put | output | 1 | `snk_data` valid this cycle |
| irq | output | 1 | High while any done bit is set |

## Verification
A table of four buffers runs through alternating sets. The buffers mix both directions, lengths from two to five words and memory latencies from zero to three wait cycles. These cases separate correct per-word address and length stepping from off-by-one termination, and they separate handshake holding from early release under slow acknowledges. Starting each table entry on the set that is not live exercises the idle hand-over. A held-back source lets both sets be armed at once, which shows the automatic flip and its order apart from a software restart, and leaves a window in which writes to the running set can be shown to be dropped. A zero-length buffer and a completion with the partner unarmed cover the two ways the channel comes to rest.

// File: rtl/pp_dma_pkg.sv
`timescale 1ns/1ps
// Package: pp_dma_pkg
// Shared register indices, command-bit positions and engine state type
// for the ping-pong DMA channel. Assumes two descriptor sets per channel.
package pp_dma_pkg;
    localparam int unsigned SET_CNT   = 2;
    localparam logic [1:0]  RIDX_ADDR = 2'd0;
    localparam logic [1:0]  RIDX_LEN  = 2'd1;
    localparam logic [1:0]  RIDX_CMD  = 2'd2;
    localparam int unsigned CB_ARM    = 0;
    localparam int unsigned CB_DONE   = 1;
    localparam int unsigned CB_LIVE   = 2;
    localparam int unsigned CB_DIR    = 4;

    typedef enum logic {
        ENG_WAIT = 1'b0,
        ENG_MEM  = 1'b1
    } eng_state_e;
endpackage

// File: rtl/pp_dma_desc_set.sv
`timescale 1ns/1ps
// Module: pp_dma_desc_set
// One descriptor set: buffer address, byte length, arm, direction and a
// sticky done flag. Software writes are dropped while the set is locked
// (live and armed). A word advance moves address up and length down by one
// word. A completion clears arm and sets done.
// Assumes adv and cmpl are only given while this set is live.
module pp_dma_desc_set #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned STEP_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_len,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [LEN_W-1:0]  new_len,
    input  logic              new_arm,
    input  logic              new_dir,
    input  logic              clr_done,
    input  logic              locked,
    input  logic              adv,
    input  logic              cmpl,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              arm,
    output logic              dir,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1) << STEP_LSB;
    localparam logic [LEN_W-1:0]  LEN_STEP  = LEN_W'(1) << STEP_LSB;
    localparam logic [ADDR_W-1:0] ADDR_MASK = ~(ADDR_STEP - ADDR_W'(1));
    localparam logic [LEN_W-1:0]  LEN_MASK  = ~(LEN_STEP - LEN_W'(1));

    // Address and length: word stepping has priority over software loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr <= '0;
            buf_len  <= '0;
        end else if (adv) begin
            buf_addr <= buf_addr + ADDR_STEP;
            buf_len  <= buf_len - LEN_STEP;
        end else if (!locked) begin
            if (wr_addr) buf_addr <= new_addr & ADDR_MASK;
            if (wr_len)  buf_len  <= new_len & LEN_MASK;
        end
    end

    // Arm and direction: completion disarms; software edits only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm <= 1'b0;
            dir <= 1'b0;
        end else if (cmpl) begin
            arm <= 1'b0;
        end else if (wr_cmd && !locked) begin
            arm <= new_arm;
            dir <= new_dir;
        end
    end

    // Sticky done flag: set on completion, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)                 done <= 1'b0;
        else if (cmpl)              done <= 1'b1;
        else if (wr_cmd && clr_done) done <= 1'b0;
    end

    p_adv_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> buf_len != '0);
    p_cmpl_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl |=> done && !arm);
    p_locked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !adv |=> $stable(buf_addr) && $stable(buf_len));
endmodule

// File: rtl/pp_dma_ctrl.sv
`timescale 1ns/1ps
// Module: pp_dma_ctrl
// Live-set pointer and completion detection. The live set runs while
// armed. It completes when its length is zero and the engine is between
// words. Control moves to the other set when that set is armed and the live
// one has just completed or is idle.
module pp_dma_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] arm,
    input  logic       act_len_zero,
    input  logic       eng_idle,
    output logic       act,
    output logic       running,
    output logic [1:0] cmpl
);
    logic cmpl_now;
    logic other_armed;

    // Completion and hand-over conditions for the live set.
    always_comb begin
        running     = arm[act];
        other_armed = arm[!act];
        cmpl_now    = running && act_len_zero && eng_idle;
        cmpl        = 2'b00;
        cmpl[act]   = cmpl_now;
    end

    // Live pointer: flip to the armed partner after completion or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   act <= 1'b0;
        else if (other_armed && (cmpl_now || !running)) act <= !act;
    end

    p_flip_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_now && other_armed |=> act != $past(act));
    p_stay_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_now && !other_armed |=> $stable(act));
    p_idle_handover_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running && other_armed |=> act != $past(act));
endmodule

// File: rtl/pp_dma_engine.sv
`timescale 1ns/1ps
// Module: pp_dma_engine
// Moves one word per memory handshake. Toward memory, it takes a word
// from the source and then holds a write request until acknowledged. From
// memory, it raises a read request when the sink asks and hands the word to
// the sink the cycle after the acknowledge. Assumes go drops once the live
// length reaches zero.
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              to_periph,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              src_rdy,
    input  logic [DATA_W-1:0] src_data,
    input  logic              snk_need,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              src_take,
    output logic              snk_put,
    output logic [DATA_W-1:0] snk_data,
    output logic              adv,
    output logic              idle
);
    eng_state_e        state_q;
    logic              we_q;
    logic              put_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] snk_q;

    // Handshake outputs decoded from the word state.
    always_comb begin
        idle      = state_q == ENG_WAIT;
        mem_req   = state_q == ENG_MEM;
        mem_we    = we_q;
        mem_wdata = hold_q;
        adv       = mem_req && mem_ack;
        src_take  = idle && go && !to_periph && src_rdy;
        snk_put   = put_q;
        snk_data  = snk_q;
    end

    // Word state: launch on peripheral readiness, retire on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_WAIT;
            we_q    <= 1'b0;
            hold_q  <= '0;
        end else if (state_q == ENG_WAIT) begin
            if (src_take) begin
                hold_q  <= src_data;
                we_q    <= 1'b1;
                state_q <= ENG_MEM;
            end else if (go && to_periph && snk_need) begin
                we_q    <= 1'b0;
                state_q <= ENG_MEM;
            end
        end else if (mem_ack) begin
            state_q <= ENG_WAIT;
        end
    end

    // Sink delivery: register the read word and pulse put once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            put_q <= 1'b0;
            snk_q <= '0;
        end else begin
            put_q <= adv && !we_q;
            if (adv && !we_q) snk_q <= mem_rdata;
        end
    end

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_wdata));
    p_put_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snk_put |-> $past(adv) && !$past(mem_we));
    p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({src_take, snk_put}));
endmodule

// File: rtl/pp_dma_chan.sv
`timescale 1ns/1ps
// Module: pp_dma_chan
// One ping-pong DMA channel: two descriptor sets, a live-set controller and
// a word engine. Decodes the word-indexed register port. Routes the live
// set's address and direction to the engine. Raises irq while any done flag is set.
// Assumes ADDR_W <= 32 and a 32-bit data path.
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              src_rdy,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_take,
    input  logic              snk_need,
    output logic [DATA_W-1:0] snk_data,
    output logic              snk_put,
    output logic              irq
);
    localparam int unsigned STEP_LSB = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] addr_q [SET_CNT];
    logic [LEN_W-1:0]  len_q  [SET_CNT];
    logic [1:0]        arm_v, dir_v, done_v, cmpl_v;
    logic              act, running, eng_adv, eng_idle, act_len_zero, go;
    logic              sel_set;
    logic [1:0]        sel_reg;

    // Register port field split.
    always_comb begin
        sel_set = reg_idx[2];
        sel_reg = reg_idx[1:0];
    end

    for (genvar s = 0; s < SET_CNT; s++) begin : g_set
        pp_dma_desc_set #(
            .ADDR_W  (ADDR_W),
            .LEN_W   (LEN_W),
            .STEP_LSB(STEP_LSB)
        ) u_set (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_addr (reg_we && sel_set == 1'(s) && sel_reg == RIDX_ADDR),
            .wr_len  (reg_we && sel_set == 1'(s) && sel_reg == RIDX_LEN),
            .wr_cmd  (reg_we && sel_set == 1'(s) && sel_reg == RIDX_CMD),
            .new_addr(reg_wdata[ADDR_W-1:0]),
            .new_len (reg_wdata[LEN_W-1:0]),
            .new_arm (reg_wdata[CB_ARM]),
            .new_dir (reg_wdata[CB_DIR]),
            .clr_done(reg_wdata[CB_DONE]),
            .locked  (act == 1'(s) && arm_v[s]),
            .adv     (eng_adv && act == 1'(s)),
            .cmpl    (cmpl_v[s]),
            .buf_addr(addr_q[s]),
            .buf_len (len_q[s]),
            .arm     (arm_v[s]),
            .dir     (dir_v[s]),
            .done    (done_v[s])
        );
    end

    // Live-set view for controller and engine.
    always_comb begin
        act_len_zero = len_q[act] == '0;
        go           = running && !act_len_zero;
        mem_addr     = addr_q[act];
        irq          = |done_v;
    end

    pp_dma_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm         (arm_v),
        .act_len_zero(act_len_zero),
        .eng_idle    (eng_idle),
        .act         (act),
        .running     (running),
        .cmpl        (cmpl_v)
    );

    pp_dma_engine #(.DATA_W(DATA_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .to_periph(dir_v[act]),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .src_rdy  (src_rdy),
        .src_data (src_data),
        .snk_need (snk_need),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .src_take (src_take),
        .snk_put  (snk_put),
        .snk_data (snk_data),
        .adv      (eng_adv),
        .idle     (eng_idle)
    );

    // Read mux: address, length or assembled command word of the chosen set.
    always_comb begin
        reg_rdata = '0;
        unique case (sel_reg)
            RIDX_ADDR: reg_rdata = 32'(addr_q[sel_set]);
            RIDX_LEN:  reg_rdata = 32'(len_q[sel_set]);
            RIDX_CMD: begin
                reg_rdata[CB_ARM]  = arm_v[sel_set];
                reg_rdata[CB_DONE] = done_v[sel_set];
                reg_rdata[CB_LIVE] = act == sel_set;
                reg_rdata[CB_DIR]  = dir_v[sel_set];
            end
            default:   reg_rdata = '0;
        endcase
    end

    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr));
    p_empty_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        running && act_len_zero |-> !mem_req);
    p_unarmed_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !src_take);
endmodule

// File: tb/pp_dma_chan_tb_top.sv
`timescale 1ns/1ps
// Bench: table-driven buffers through alternating sets, then directed
// cases for reset, field masking, ping-pong order, write lock and empty sets.
module pp_dma_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        src_rdy, src_take, snk_need, snk_put, irq;
    logic [31:0] src_data, snk_data;

    logic [31:0] mem [64];
    logic [31:0] sink [16];
    int          sink_n, ack_cnt, cnt, lat;
    logic [31:0] src_ctr;
    logic        src_en = 1'b1;
    int          n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    pp_dma_chan dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .src_rdy(src_rdy),
        .src_data(src_data), .src_take(src_take), .snk_need(snk_need),
        .snk_data(snk_data), .snk_put(snk_put), .irq(irq)
    );

    assign src_rdy  = src_en;
    assign snk_need = 1'b1;
    assign src_data = 32'hA500_0000 + src_ctr;

    // Memory model with a programmable number of wait cycles.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            cnt       <= 0;
            ack_cnt   <= 0;
            for (int j = 0; j < 64; j++) mem[j] <= 32'h1000_0000 + 32'(j);
        end else begin
            if (mem_ack) ack_cnt <= ack_cnt + 1;
            if (mem_req && !mem_ack) begin
                if (cnt >= lat) begin
                    mem_ack <= 1'b1;
                    cnt     <= 0;
                    if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                    else        mem_rdata <= mem[mem_addr[7:2]];
                end else begin
                    cnt <= cnt + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // Peripheral source and sink models.
    always @(posedge clk) begin
        if (!rst_n) begin
            src_ctr <= '0;
            sink_n  <= 0;
        end else begin
            if (src_take) src_ctr <= src_ctr + 1;
            if (snk_put) begin
                sink[sink_n[3:0]] <= snk_data;
                sink_n <= sink_n + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string tag);
        int n;
        n = 0;
        while (!irq && n < 2000) begin @(negedge clk); n++; end
        chk(tag, 32'(irq), 32'd1);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Table: {address, length in bytes, direction, wait cycles}.
    localparam logic [47:0] VEC [4] = '{
        {32'h0000_0040, 12'd16, 1'b0, 3'd0},
        {32'h0000_0080, 12'd12, 1'b1, 3'd2},
        {32'h0000_00C0, 12'd8,  1'b0, 3'd3},
        {32'h0000_0010, 12'd20, 1'b1, 3'd1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int a0, k0;
        logic [31:0] s0;
        lat = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_rd(3'd0, rd); chk("R1 set0 addr", rd, 32'h0);
        reg_rd(3'd1, rd); chk("R1 set0 len", rd, 32'h0);
        reg_rd(3'd2, rd); chk("R1 set0 cmd", rd, 32'h4);
        reg_rd(3'd4, rd); chk("R1 set1 addr", rd, 32'h0);
        reg_rd(3'd5, rd); chk("R1 set1 len", rd, 32'h0);
        reg_rd(3'd6, rd); chk("R1 set1 cmd", rd, 32'h0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 mem_req", 32'(mem_req), 32'd0);

        // R2 field masking and command layout
        reg_wr(3'd0, 32'h0000_1237); reg_rd(3'd0, rd); chk("R2 addr mask", rd, 32'h1234);
        reg_wr(3'd1, 32'h7);         reg_rd(3'd1, rd); chk("R2 len mask", rd, 32'h4);
        reg_wr(3'd2, 32'h10);        reg_rd(3'd2, rd); chk("R2 cmd dir+live", rd, 32'h14);
        reg_wr(3'd2, 32'h0); reg_wr(3'd0, 32'h0); reg_wr(3'd1, 32'h0);

        // Table walk: R3, R4, R5, R6, R9
        for (int i = 0; i < 4; i++) begin
            logic [31:0] va;
            logic [11:0] vl;
            logic        vd;
            logic [2:0]  vt;
            logic [2:0]  base;
            {va, vl, vd, vt} = VEC[i];
            base = i[0] ? 3'd4 : 3'd0;
            lat  = int'(vt);
            a0 = ack_cnt; s0 = src_ctr; k0 = sink_n;
            reg_wr(base | 3'd0, va);
            reg_wr(base | 3'd1, 32'(vl));
            reg_wr(base | 3'd2, {27'b0, vd, 4'b0001});
            wait_irq("R5 R9 irq after buffer");
            for (int w = 0; w < int'(vl) / 4; w++) begin
                if (vd) chk("R4 sink word", sink[(k0 + w) % 16],
                            32'h1000_0000 + 32'(va[7:2]) + 32'(w));
                else    chk("R3 memory word", mem[va[7:2] + 6'(w)], 32'hA500_0000 + s0 + 32'(w));
            end
            chk("R3 ack count", 32'(ack_cnt - a0), 32'(vl) / 4);
            reg_rd(base | 3'd0, rd); chk("R3 final addr", rd, va + 32'(vl));
            reg_rd(base | 3'd1, rd); chk("R3 final len", rd, 32'h0);
            reg_rd(base | 3'd2, rd); chk("R5 cmd done", rd, {27'b0, vd, 4'b0110});
            reg_wr(base | 3'd2, 32'h0);
            chk("R6 write 0 keeps irq", 32'(irq), 32'd1);
            reg_wr(base | 3'd2, 32'h2);
            chk("R6 write 1 clears irq", 32'(irq), 32'd0);
        end

        // R8 finished set stays live when partner unarmed
        reg_rd(3'd6, rd); chk("R8 set1 still live", rd, 32'h4);
        reg_rd(3'd2, rd); chk("R8 set0 not live", rd, 32'h0);
        a0 = ack_cnt;
        repeat (20) @(negedge clk);
        chk("R8 no traffic", 32'(ack_cnt - a0), 32'd0);

        // R10 lock on running set, R7 ping-pong
        lat = 1;
        src_en = 1'b0;
        reg_wr(3'd4, 32'hB0); reg_wr(3'd5, 32'd8); reg_wr(3'd6, 32'h1);
        reg_wr(3'd4, 32'h0);  reg_rd(3'd4, rd); chk("R10 locked addr", rd, 32'hB0);
        reg_wr(3'd5, 32'd32); reg_rd(3'd5, rd); chk("R10 locked len", rd, 32'd8);
        reg_wr(3'd6, 32'h0);  reg_rd(3'd6, rd); chk("R10 locked arm", rd, 32'h5);
        reg_wr(3'd0, 32'hA0); reg_rd(3'd0, rd); chk("R10 idle set writable", rd, 32'hA0);
        reg_wr(3'd1, 32'd8);  reg_wr(3'd2, 32'h1);
        a0 = ack_cnt; s0 = src_ctr;
        src_en = 1'b1;
        wait_irq("R7 first set done");
        repeat (60) @(negedge clk);
        chk("R7 set1 word0", mem[44], 32'hA500_0000 + s0);
        chk("R7 set1 word1", mem[45], 32'hA500_0001 + s0);
        chk("R7 set0 word0", mem[40], 32'hA500_0002 + s0);
        chk("R7 set0 word1", mem[41], 32'hA500_0003 + s0);
        chk("R7 ack count", 32'(ack_cnt - a0), 32'd4);
        reg_rd(3'd2, rd); chk("R7 set0 live done", rd, 32'h6);
        reg_rd(3'd6, rd); chk("R7 set1 done", rd, 32'h2);
        reg_wr(3'd2, 32'h2); reg_wr(3'd6, 32'h2);
        chk("R6 all cleared", 32'(irq), 32'd0);

        // R11 zero-length set
        reg_wr(3'd4, 32'h20); reg_wr(3'd5, 32'h0);
        a0 = ack_cnt;
        reg_wr(3'd6, 32'h1);
        wait_irq("R11 empty set completes");
        repeat (5) @(negedge clk);
        chk("R11 no memory traffic", 32'(ack_cnt - a0), 32'd0);
        reg_rd(3'd6, rd); chk("R11 cmd live done", rd, 32'h6);
        reg_rd(3'd4, rd); chk("R11 addr unchanged", rd, 32'h20);

        report();
        $finish;
    end
endmodule